// File: doc/BRIEF.md
# Dual-Channel Serial Pixel Lane Packer

This block turns a stream of pixel pairs into the serial bit streams of a two-channel low-voltage differential display link. On every pixel clock it takes one odd pixel and one even pixel, each 24-bit RGB888, plus a data-enable flag. Each pixel is packed into four 7-bit lane words by a fixed bit map. The two most significant bits of every colour are grouped on the fourth lane, and the data-enable flag rides on the third.

A bit clock running at seven times the pixel rate shifts every lane out one bit per bit-clock cycle. Alongside the data, each channel gets a clock-lane stream that is high for four bit slots and low for three. The first pixel of a line belongs on the odd channel. Both channels run in lockstep, so a downstream receiver can treat them as one wide link.

The outputs are single-ended bit streams that feed an external differential driver. Clock generation and analog signalling sit outside this block.

Top module: `lvds_pair_packer`

## Requirements
- R1: The pixel on `odd_rgb` appears only on the odd channel outputs, and the pixel on `even_rgb` appears only on the even channel outputs.
- R2: Pixel fields are R = rgb[23:16], G = rgb[15:8], B = rgb[7:0]. On lane 0, slots 0 to 5 carry R0 to R5 and slot 6 carries G0.
- R3: On lane 1, slots 0 to 4 carry G1 to G5, slot 5 carries B0 and slot 6 carries B1.
- R4: On lane 2, slots 0 to 3 carry B2 to B5, slots 4 and 5 are driven low, and slot 6 carries the data-enable flag.
- R5: On lane 3, slots 0 to 5 carry R6, R7, G6, G7, B6 and B7, and slot 6 is driven low.
- R6: Over slots 0 to 6, each clock lane emits the pattern 1,1,0,0,0,1,1. It is high for four bit periods and low for three in every pixel period.
- R7: The odd and even clock lanes are identical in every bit cycle, and both channels place their slots in the same bit cycles.
- R8: Every lane emits slot 0 first and slot 6 last. All eight data lanes are loaded on the same bit-clock edge, and slot 0 coincides with the first high bit of the clock-lane pattern.
- R9: While `rst_n` is low, all eight data lanes output zero and both clock lanes keep producing the R6 pattern.
- R10: Each pixel period carries exactly one pixel pair. When the inputs change on every pixel clock, consecutive serial frames carry consecutive pixel pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| pix_clk | input | 1 | Pixel clock, one pixel pair per rising edge |
| bit_clk | input | 1 | Serial bit clock, seven times the pixel clock and phase locked to it |
| odd_rgb | input | 24 | Odd (first) pixel of the pair, {R,G,B} |
| even_rgb | input | 24 | Even (second) pixel of the pair, {R,G,B} |
| de | input | 1 | Data-enable flag for the pair |
| odd_lane | output | 4 | Serial data streams of odd channel lanes 3..0 |
| even_lane | output | 4 | Serial data streams of even channel lanes 3..0 |
| odd_clk_lane | output | 1 | Clock-lane stream of the odd channel |
| even_clk_lane | output | 1 | Clock-lane stream of the even channel |

## Verification
The properties assume that `bit_clk` is exactly seven times `pix_clk`, with rising edges phase locked to it. They also assume that pixel inputs are steady around each `pix_clk` rising edge, so that a pixel held in the capture register is stable for the whole bit period that loads it. The bench produces both clocks from one loop that raises `pix_clk` on every seventh `bit_clk` rising edge, and changes pixel inputs only on `pix_clk` falling edges. Output frames are located by watching the falling edge of the clock lane, not by counting internal latency. Comparisons therefore rest only on the slot positions stated in R2 to R8.

// File: rtl/lvds_pack_pkg.sv
package lvds_pack_pkg;

  localparam int PIX_W  = 24;
  localparam int COL_W  = PIX_W / 3;
  localparam int LANES  = 4;
  localparam int LANE_W = 7;

  typedef logic [LANE_W-1:0] lane_word_t;
  typedef lane_word_t [LANES-1:0] chan_words_t;

  // Clock-lane level per serial slot, slot 0 in bit 0.
  localparam lane_word_t CLK_PATTERN = 7'b1100011;

  // Lane word bit k is emitted in serial slot k.
  function automatic chan_words_t map_pixel(input logic [PIX_W-1:0] rgb,
                                            input logic             de_f);
    logic [COL_W-1:0] r, g, b;
    chan_words_t      w;
    r    = rgb[3*COL_W-1:2*COL_W];
    g    = rgb[2*COL_W-1:COL_W];
    b    = rgb[COL_W-1:0];
    w[0] = {g[0], r[5:0]};
    w[1] = {b[1], b[0], g[5:1]};
    w[2] = {de_f, 2'b00, b[5:2]};
    w[3] = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
    return w;
  endfunction

endpackage

// File: rtl/lvds_rst_sync.sv
module lvds_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/lvds_pix_capture.sv
module lvds_pix_capture
  import lvds_pack_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0][PIX_W-1:0]   rgb_i,
  input  logic                        de_i,
  output chan_words_t [NCH-1:0]       words_o
);

  chan_words_t [NCH-1:0] words_d;
  chan_words_t [NCH-1:0] words_q;

  // Pack each channel's pixel into its lane words.
  for (genvar c = 0; c < NCH; c++) begin : g_map
    assign words_d[c] = map_pixel(rgb_i[c], de_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) words_q <= '0;
    else        words_q <= words_d;
  end

  assign words_o = words_q;

endmodule

// File: rtl/lvds_lane_ser.sv
module lvds_lane_ser
  import lvds_pack_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  chan_words_t [NCH-1:0]        words_i,
  output logic [NCH-1:0][LANES-1:0]    data_o,
  output logic [NCH-1:0]               clk_o
);

  localparam int LAST   = LANE_W - 1;
  localparam int SLOT_W = $clog2(LANE_W);

  logic [SLOT_W-1:0]     slot_q, slot_d;
  logic                  load_en;
  chan_words_t [NCH-1:0] sh_q, sh_d;
  logic [NCH-1:0]        clk_q;

  // Slot counter: free running, not reset, settles to 0 from any state.
  always_comb begin
    slot_d = '0;
    for (int k = 0; k < LAST; k++) begin
      if (slot_q == SLOT_W'(k)) slot_d = SLOT_W'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    slot_q <= slot_d;
  end

  assign load_en = (slot_q == SLOT_W'(LAST));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign sh_d[c][l]   = load_en ? words_i[c][l]
                                    : {1'b0, sh_q[c][l][LANE_W-1:1]};
      assign data_o[c][l] = sh_q[c][l][0];
    end

    // Clock lane of each channel has its own flop, fed from the shared slot.
    always_ff @(posedge clk) begin
      clk_q[c] <= CLK_PATTERN[slot_d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign clk_o = clk_q;

endmodule

// File: rtl/lvds_pair_packer.sv
module lvds_pair_packer
  import lvds_pack_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             pix_clk,
  input  logic             bit_clk,
  input  logic [PIX_W-1:0] odd_rgb,
  input  logic [PIX_W-1:0] even_rgb,
  input  logic             de,
  output logic [LANES-1:0] odd_lane,
  output logic [LANES-1:0] even_lane,
  output logic             odd_clk_lane,
  output logic             even_clk_lane
);

  localparam int NCH = 2;

  logic                      pix_rst_n;
  logic                      bit_rst_n;
  logic [NCH-1:0][PIX_W-1:0] rgb_in;
  chan_words_t [NCH-1:0]     words;
  logic [NCH-1:0][LANES-1:0] lane_bits;
  logic [NCH-1:0]            clk_bits;

  lvds_rst_sync #(.STAGES(SYNC_STAGES)) u_pix_rst (
    .clk(pix_clk), .rst_n_in(rst_n), .rst_n_out(pix_rst_n));

  lvds_rst_sync #(.STAGES(SYNC_STAGES)) u_bit_rst (
    .clk(bit_clk), .rst_n_in(rst_n), .rst_n_out(bit_rst_n));

  // Channel 0 is odd (first pixel), channel 1 is even.
  assign rgb_in = {even_rgb, odd_rgb};

  lvds_pix_capture #(.NCH(NCH)) u_cap (
    .clk(pix_clk), .rst_n(pix_rst_n), .rgb_i(rgb_in), .de_i(de),
    .words_o(words));

  lvds_lane_ser #(.NCH(NCH)) u_ser (
    .clk(bit_clk), .rst_n(bit_rst_n), .words_i(words),
    .data_o(lane_bits), .clk_o(clk_bits));

  assign odd_lane      = lane_bits[0];
  assign even_lane     = lane_bits[1];
  assign odd_clk_lane  = clk_bits[0];
  assign even_clk_lane = clk_bits[1];

endmodule

// File: rtl/lvds_pair_packer_chk.sv
module lvds_pair_packer_chk (
  input logic       rst_n,
  input logic       bit_clk,
  input logic [3:0] odd_lane,
  input logic [3:0] even_lane,
  input logic       odd_clk_lane,
  input logic       even_clk_lane
);

  // R6: a rising clock lane stays high for four slots in total
  a_r6_high_run: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(odd_clk_lane) |=> odd_clk_lane ##1 odd_clk_lane ##1 odd_clk_lane
                            ##1 !odd_clk_lane);

  // R6: a falling clock lane stays low for three slots in total
  a_r6_low_run: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(odd_clk_lane) |=> !odd_clk_lane ##1 !odd_clk_lane ##1 odd_clk_lane);

  // R7: both channels share the same clock-lane timing
  a_r7_lockstep: assert property (@(posedge bit_clk) disable iff (!rst_n)
    odd_clk_lane == even_clk_lane);

  // R4 / R5: pad slots (lane 2 slots 4,5; lane 3 slot 6) are low; fall marks slot 2
  a_r4_pad_zero: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(odd_clk_lane) |-> ##2 (!odd_lane[2] && !even_lane[2])
                            ##1 (!odd_lane[2] && !even_lane[2])
                            ##1 (!odd_lane[3] && !even_lane[3]));

endmodule

bind lvds_pair_packer lvds_pair_packer_chk u_chk (
  .rst_n(rst_n), .bit_clk(bit_clk), .odd_lane(odd_lane),
  .even_lane(even_lane), .odd_clk_lane(odd_clk_lane),
  .even_clk_lane(even_clk_lane));

// File: tb/lvds_pair_packer_bench.sv
module lvds_pair_packer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;
  localparam int WD_CYCLES  = 20000;

  // {odd_rgb, even_rgb, de}
  localparam logic [48:0] VEC [NVEC] = '{
    {24'hFFFFFF, 24'h000000, 1'b1},
    {24'h000000, 24'hFFFFFF, 1'b0},
    {24'hA5C33C, 24'h5A3CC3, 1'b1},
    {24'h010203, 24'h808080, 1'b1},
    {24'h80FF01, 24'h7F0080, 1'b0},
    {24'h123456, 24'hFEDCBA, 1'b1}
  };

  logic        rst_n, pix_clk, bit_clk, de;
  logic [23:0] odd_rgb, even_rgb;
  logic [3:0]  odd_lane, even_lane;
  logic        odd_clk_lane, even_clk_lane;

  int checks = 0;
  int errors = 0;

  logic [6:0] cap_o [2][4];
  logic [6:0] cap_e [2][4];
  logic [6:0] cap_oc [2];
  logic [6:0] cap_ec [2];

  logic        alt_mode = 1'b0;
  logic        alt_sel  = 1'b0;
  localparam logic [23:0] A_O = 24'h0F1E2D, A_E = 24'hC0FFEE;
  localparam logic [23:0] B_O = 24'hE1D2C3, B_E = 24'h3355AA;

  lvds_pair_packer u_lvds_pair_packer (
    .rst_n(rst_n), .pix_clk(pix_clk), .bit_clk(bit_clk),
    .odd_rgb(odd_rgb), .even_rgb(even_rgb), .de(de),
    .odd_lane(odd_lane), .even_lane(even_lane),
    .odd_clk_lane(odd_clk_lane), .even_clk_lane(even_clk_lane));

  // One loop makes both clocks: pix_clk rises with every 7th bit_clk rise.
  initial begin
    bit_clk = 1'b0;
    pix_clk = 1'b0;
    forever begin
      for (int k = 0; k < 7; k++) begin
        #(CLK_PERIOD/2);
        bit_clk = 1'b1;
        if (k == 0) pix_clk = 1'b1;
        if (k == 4) pix_clk = 1'b0;
        #(CLK_PERIOD/2);
        bit_clk = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    errors++;
    $display("FAIL R10 watchdog expired: got=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Expected lane words, slot k in bit k: {lane3, lane2, lane1, lane0}
  function automatic logic [27:0] exp_chan(input logic [23:0] p, input logic d);
    logic [6:0] l0, l1, l2, l3;
    l0 = {p[8], p[21:16]};
    l1 = {p[1:0], p[13:9]};
    l2 = {d, 2'b00, p[5:2]};
    l3 = {1'b0, p[7:6], p[15:14], p[23:22]};
    return {l3, l2, l1, l0};
  endfunction

  task automatic chk(input string tag, input logic [27:0] got, input logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Locate slot 2 by the clock-lane fall, then collect nf frames from slot 0.
  task automatic capture(input int nf);
    logic prev;
    @(negedge bit_clk);
    prev = odd_clk_lane;
    for (int i = 0; i < 20; i++) begin
      @(negedge bit_clk);
      if (prev && !odd_clk_lane) break;
      prev = odd_clk_lane;
    end
    repeat (5) @(negedge bit_clk);
    for (int f = 0; f < nf; f++) begin
      for (int s = 0; s < 7; s++) begin
        for (int l = 0; l < 4; l++) begin
          cap_o[f][l][s] = odd_lane[l];
          cap_e[f][l][s] = even_lane[l];
        end
        cap_oc[f][s] = odd_clk_lane;
        cap_ec[f][s] = even_clk_lane;
        if (!(f == nf - 1 && s == 6)) @(negedge bit_clk);
      end
    end
  endtask

  always @(negedge pix_clk) begin
    if (alt_mode) begin
      odd_rgb  <= alt_sel ? B_O : A_O;
      even_rgb <= alt_sel ? B_E : A_E;
      alt_sel  <= ~alt_sel;
    end
  end

  initial begin
    logic [27:0] eo, ee, go0, ge0, go1, ge1, ea_o, ea_e, eb_o, eb_e;
    int          ones, nz;
    string       rq [4];
    rq = '{"R2", "R3", "R4", "R5"};
    rst_n = 1'b0; de = 1'b0; odd_rgb = '0; even_rgb = '0;

    // Reset state (R9): lanes zero, clock pattern running
    repeat (10) @(negedge bit_clk);
    nz = 0; ones = 0;
    for (int s = 0; s < 7; s++) begin
      @(negedge bit_clk);
      if (odd_lane != 0 || even_lane != 0) nz++;
      ones += int'(odd_clk_lane);
    end
    chk("R9 data zero in reset", 28'(nz), 28'd0);
    chk("R9 clock ones in reset", 28'(ones), 28'd4);

    @(negedge pix_clk);
    rst_n = 1'b1;

    // Table of vectors
    for (int v = 0; v < NVEC; v++) begin
      @(negedge pix_clk);
      {odd_rgb, even_rgb, de} = VEC[v];
      repeat (3) @(negedge pix_clk);
      capture(1);
      eo = exp_chan(VEC[v][48:25], VEC[v][0]);
      ee = exp_chan(VEC[v][24:1], VEC[v][0]);
      for (int l = 0; l < 4; l++) begin
        chk($sformatf("%s R8 R1 odd lane%0d vec%0d", rq[l], l, v),
            28'(cap_o[0][l]), 28'(eo[7*l +: 7]));
        chk($sformatf("%s R8 R1 even lane%0d vec%0d", rq[l], l, v),
            28'(cap_e[0][l]), 28'(ee[7*l +: 7]));
      end
      chk($sformatf("R6 odd clock pattern vec%0d", v), 28'(cap_oc[0]), 28'h63);
      chk($sformatf("R7 even clock matches vec%0d", v), 28'(cap_ec[0]), 28'(cap_oc[0]));
    end

    // R10: a new pair every pixel clock lands in consecutive frames
    de = 1'b1;
    alt_mode = 1'b1;
    repeat (3) @(negedge pix_clk);
    capture(2);
    alt_mode = 1'b0;
    ea_o = exp_chan(A_O, 1'b1); ea_e = exp_chan(A_E, 1'b1);
    eb_o = exp_chan(B_O, 1'b1); eb_e = exp_chan(B_E, 1'b1);
    go0 = {cap_o[0][3], cap_o[0][2], cap_o[0][1], cap_o[0][0]};
    ge0 = {cap_e[0][3], cap_e[0][2], cap_e[0][1], cap_e[0][0]};
    go1 = {cap_o[1][3], cap_o[1][2], cap_o[1][1], cap_o[1][0]};
    ge1 = {cap_e[1][3], cap_e[1][2], cap_e[1][1], cap_e[1][0]};
    if (go0 == ea_o) begin
      chk("R10 frame0 even", ge0, ea_e);
      chk("R10 frame1 odd", go1, eb_o);
      chk("R10 frame1 even", ge1, eb_e);
    end else begin
      chk("R10 frame0 odd", go0, eb_o);
      chk("R10 frame0 even", ge0, eb_e);
      chk("R10 frame1 odd", go1, ea_o);
      chk("R10 frame1 even", ge1, ea_e);
    end

    // R9: reset mid-stream with all-ones pixels
    @(negedge pix_clk);
    odd_rgb = 24'hFFFFFF; even_rgb = 24'hFFFFFF; de = 1'b1;
    repeat (3) @(negedge pix_clk);
    @(negedge bit_clk);
    rst_n = 1'b0;
    nz = 0; ones = 0;
    for (int s = 0; s < 14; s++) begin
      @(negedge bit_clk);
      if (odd_lane != 0 || even_lane != 0) nz++;
      ones += int'(odd_clk_lane);
      if (odd_clk_lane != even_clk_lane) nz++;
    end
    chk("R9 lanes zero during reset", 28'(nz), 28'd0);
    chk("R9 clock keeps running in reset", 28'(ones), 28'd8);

    @(negedge pix_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge pix_clk);
    capture(1);
    eo = exp_chan(24'hFFFFFF, 1'b1);
    chk("R9 R2 odd restored after reset",
        {cap_o[0][3], cap_o[0][2], cap_o[0][1], cap_o[0][0]}, eo);
    chk("R4 even pad slots after reset",
        {cap_e[0][3], cap_e[0][2], cap_e[0][1], cap_e[0][0]}, eo);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule